// File: doc/BRIEF.md
# Control-Transfer Target Guard

The guard decides whether a pointer that is about to be used as the destination of an indirect call or jump belongs to a permitted set of destinations. Each request describes that set compactly. It gives a region base and a failure-handler offset, both as signed offsets from the program counter of the checking instruction. It also gives an alignment exponent, a count of slots in the region, an inline membership vector and a check mode. The guard replies with one verdict per request: pass, trap, or jump to a handler, and with the jump it gives the resolved handler address.

Alignment and bounds are tested with one comparison. The base is subtracted from the pointer, and the 64-bit difference is rotated right by the alignment exponent. Any set low bits of a misaligned pointer land in the top of the word, and a pointer below the base wraps to a very large value. The rotated slot index is then compared, unsigned, against the slot count. The modes that use a vector also test the selected bit of a 32-bit or 64-bit inline vector. Single-destination mode compares the pointer directly against the base. The unit is a two-stage pipeline with a valid/ready handshake on both sides. It accepts one request per cycle, and under backpressure it holds its result.

Top module: `cft_guard`

## Requirements
- R1: In span mode (mode 2'b00), a pointer with base <= ptr < base + (size << align) and zero low `align` bits passes; the base is in_pc plus the sign-extended 28-bit in_base_off.
- R2: A pointer below the base, or at or above base + (size << align), fails in every mode other than single-destination mode.
- R3: A pointer whose offset from the base has any of its low `align` bits set fails, even when it lies inside the region.
- R4: In 64-bit vector mode (mode 2'b10), a pointer that is in range and aligned passes only if bit `index` of in_vec is 1, where index = (ptr - base) >> align.
- R5: In 32-bit vector mode (mode 2'b01), only in_vec[31:0] is used, and an index of 32 or more fails even when it is below the slot count.
- R6: A slot count of zero fails in span and vector modes, whatever the pointer.
- R7: In single-destination mode (mode 2'b11), the verdict is pass exactly when ptr equals the base, and in_size, in_align and in_vec have no effect.
- R8: Verdict codes are 2'b01 pass, 2'b10 trap and 2'b11 jump. A failed check with in_fail_off zero gives trap. A failed check with any other in_fail_off gives jump, with out_target = in_pc + sign-extended in_fail_off. out_target is zero for any code other than jump.
- R9: A request accepted at a clock edge produces its verdict two edges later when out_ready is high, and requests are accepted back to back at one per cycle.
- R10: While out_valid is high and out_ready is low, out_code and out_target hold and in_ready is low. No result is lost or duplicated.
- R11: After reset, out_valid is 0, out_code is 2'b00 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge when high |
| in_ptr | input | 64 | Pointer under test |
| in_pc | input | 64 | Program counter of the checking instruction |
| in_base_off | input | 28 | Signed region-base offset from in_pc |
| in_align | input | 4 | Alignment exponent |
| in_size | input | 20 | Slot count of the region |
| in_vec | input | 64 | Inline membership vector |
| in_mode | input | 2 | 00 span, 01 vector32, 10 vector64, 11 single |
| in_fail_off | input | 28 | Signed handler offset from in_pc; zero means trap |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict at this edge |
| out_code | output | 2 | Verdict code |
| out_target | output | 64 | Handler address when the code is jump |

## Verification
A wrong internal value in this guard always shows up as a wrong verdict or a missing one, two cycles after the request is accepted. A bad rotation amount, a slot comparison that is off by one, or a wrong bit select turns pass into trap or jump, or the reverse, at exactly that cycle. A first-stage valid flag that is lost or stuck moves out_valid away from the expected cycle. State that is dropped during a stall shows as a verdict that changes while out_ready is low, or as a result that is skipped or repeated on the next cycle that out_ready is high. The reference model predicts both the verdict and its arrival cycle, so each of these faults is caught on the first affected request.

// File: rtl/cft_pkg.sv
package cft_pkg;
    parameter int PTR_W   = 64;
    parameter int OFF_W   = 28;
    parameter int ALIGN_W = 4;
    parameter int SIZE_W  = 20;
    parameter int VEC_W   = 64;
    parameter int NARROW_W = 32;

    localparam int WIDE_IDX_W   = $clog2(VEC_W);
    localparam int NARROW_IDX_W = $clog2(NARROW_W);

    typedef enum logic [1:0] {
        MODE_SPAN   = 2'b00,
        MODE_VEC32  = 2'b01,
        MODE_VEC64  = 2'b10,
        MODE_SOLO   = 2'b11
    } cft_mode_e;

    typedef enum logic [1:0] {
        VERD_NONE = 2'b00,
        VERD_PASS = 2'b01,
        VERD_TRAP = 2'b10,
        VERD_JUMP = 2'b11
    } cft_verdict_e;

    typedef struct packed {
        logic [PTR_W-1:0]  idx;
        logic [SIZE_W-1:0] size;
        cft_mode_e         mode;
        logic [VEC_W-1:0]  vec;
        logic              solo_hit;
        logic              trap_sel;
        logic [PTR_W-1:0]  handler;
    } cft_stage_t;
endpackage

// File: rtl/cft_addr_gen.sv
module cft_addr_gen
    import cft_pkg::*;
#(
    parameter int P_W = PTR_W,
    parameter int O_W = OFF_W
) (
    input  logic [P_W-1:0] pc,
    input  logic [O_W-1:0] base_off,
    input  logic [O_W-1:0] fail_off,
    output logic [P_W-1:0] base_addr,
    output logic [P_W-1:0] handler,
    output logic           trap_sel
);
    localparam int EXT_W = P_W - O_W;

    logic [P_W-1:0] base_ext;
    logic [P_W-1:0] fail_ext;

    always_comb begin
        base_ext  = {{EXT_W{base_off[O_W-1]}}, base_off};
        fail_ext  = {{EXT_W{fail_off[O_W-1]}}, fail_off};
        base_addr = pc + base_ext;
        handler   = pc + fail_ext;
        trap_sel  = (fail_off == '0);
    end
endmodule

// File: rtl/cft_index_rot.sv
module cft_index_rot
    import cft_pkg::*;
#(
    parameter int P_W = PTR_W,
    parameter int A_W = ALIGN_W
) (
    input  logic [P_W-1:0] ptr,
    input  logic [P_W-1:0] base_addr,
    input  logic [A_W-1:0] align,
    output logic [P_W-1:0] idx,
    output logic           solo_hit
);
    logic [P_W-1:0]   diff;
    logic [2*P_W-1:0] twin;

    always_comb begin
        diff     = ptr - base_addr;
        twin     = {diff, diff} >> align;
        idx      = twin[P_W-1:0];
        solo_hit = (ptr == base_addr);
    end
endmodule

// File: rtl/cft_verdict.sv
module cft_verdict
    import cft_pkg::*;
(
    input  cft_stage_t    stage,
    output cft_verdict_e  code,
    output logic [PTR_W-1:0] target
);
    logic in_span;
    logic narrow_ok;
    logic wide_ok;
    logic member;

    always_comb begin
        in_span   = (stage.idx < {{(PTR_W-SIZE_W){1'b0}}, stage.size});
        narrow_ok = (stage.idx < PTR_W'(NARROW_W)) &&
                    stage.vec[stage.idx[NARROW_IDX_W-1:0]];
        wide_ok   = (stage.idx < PTR_W'(VEC_W)) &&
                    stage.vec[stage.idx[WIDE_IDX_W-1:0]];
        unique case (stage.mode)
            MODE_SPAN:  member = in_span;
            MODE_VEC32: member = in_span && narrow_ok;
            MODE_VEC64: member = in_span && wide_ok;
            MODE_SOLO:  member = stage.solo_hit;
            default:    member = 1'b0;
        endcase
        if (member) begin
            code   = VERD_PASS;
            target = '0;
        end else if (stage.trap_sel) begin
            code   = VERD_TRAP;
            target = '0;
        end else begin
            code   = VERD_JUMP;
            target = stage.handler;
        end
    end
endmodule

// File: rtl/cft_guard.sv
module cft_guard
    import cft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PTR_W-1:0]   in_ptr,
    input  logic [PTR_W-1:0]   in_pc,
    input  logic [OFF_W-1:0]   in_base_off,
    input  logic [ALIGN_W-1:0] in_align,
    input  logic [SIZE_W-1:0]  in_size,
    input  logic [VEC_W-1:0]   in_vec,
    input  logic [1:0]         in_mode,
    input  logic [OFF_W-1:0]   in_fail_off,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_code,
    output logic [PTR_W-1:0]   out_target
);
    logic             advance;
    logic [PTR_W-1:0] base_addr;
    logic [PTR_W-1:0] handler;
    logic             trap_sel;
    logic [PTR_W-1:0] idx;
    logic             solo_hit;
    cft_stage_t       s1_next;
    cft_stage_t       s1_q;
    logic             s1_valid;
    cft_verdict_e     v_code;
    logic [PTR_W-1:0] v_target;

    cft_addr_gen u_addr (
        .pc        (in_pc),
        .base_off  (in_base_off),
        .fail_off  (in_fail_off),
        .base_addr (base_addr),
        .handler   (handler),
        .trap_sel  (trap_sel)
    );

    cft_index_rot u_rot (
        .ptr       (in_ptr),
        .base_addr (base_addr),
        .align     (in_align),
        .idx       (idx),
        .solo_hit  (solo_hit)
    );

    always_comb begin
        advance          = !out_valid || out_ready;
        in_ready         = advance;
        s1_next.idx      = idx;
        s1_next.size     = in_size;
        s1_next.mode     = cft_mode_e'(in_mode);
        s1_next.vec      = in_vec;
        s1_next.solo_hit = solo_hit;
        s1_next.trap_sel = trap_sel;
        s1_next.handler  = handler;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else if (advance) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_q <= s1_next;
            end
        end
    end

    cft_verdict u_verd (
        .stage  (s1_q),
        .code   (v_code),
        .target (v_target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_code   <= VERD_NONE;
            out_target <= '0;
        end else if (advance) begin
            out_valid  <= s1_valid;
            out_code   <= s1_valid ? v_code : VERD_NONE;
            out_target <= s1_valid ? v_target : '0;
        end
    end
endmodule

// File: rtl/cft_guard_chk.sv
module cft_guard_chk
    import cft_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_code,
    input logic [PTR_W-1:0] out_target
);
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_code != 2'b00) else $error("code"); // R8
    AST_TARGET_ONLY_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code != 2'b11) |-> out_target == '0) else $error("target"); // R8
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_target))) else $error("hold"); // R10
    AST_READY_DROPS_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready) else $error("ready"); // R10
    AST_TWO_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid) else $error("latency"); // R9
endmodule

bind cft_guard cft_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_code   (out_code),
    .out_target (out_target)
);

// File: tb/tb_cft_guard.sv
module tb_cft_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_ptr = '0;
    logic [63:0] in_pc = '0;
    logic [27:0] in_base_off = '0;
    logic [3:0]  in_align = '0;
    logic [19:0] in_size = '0;
    logic [63:0] in_vec = '0;
    logic [1:0]  in_mode = '0;
    logic [27:0] in_fail_off = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_code;
    logic [63:0] out_target;

    cft_guard dut (.*);

    always #5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit stall_phase = 0;
    bit timed = 1;

    typedef struct {
        logic [1:0]  code;
        logic [63:0] target;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] mode, input logic [3:0] al,
                                  input logic [19:0] sz, input logic [63:0] vec,
                                  input logic [63:0] ptr, input logic [63:0] pc,
                                  input logic [27:0] boff, input logic [27:0] foff,
                                  output logic [1:0] code, output logic [63:0] tgt);
        longint unsigned base = pc + {{36{boff[27]}}, boff};
        longint unsigned d;
        longint unsigned idx;
        bit ok;
        if (mode == 2'b11) ok = (ptr == base);
        else if (ptr < base) ok = 0;
        else begin
            d = ptr - base;
            if ((d & ((64'd1 << al) - 1)) != 0) ok = 0;
            else begin
                idx = d >> al;
                ok = idx < sz;
                if (mode == 2'b01) ok = ok && idx < 32 && vec[idx[5:0]];
                if (mode == 2'b10) ok = ok && idx < 64 && vec[idx[5:0]];
            end
        end
        if (ok) begin code = 2'b01; tgt = 0; end
        else if (foff == 0) begin code = 2'b10; tgt = 0; end
        else begin code = 2'b11; tgt = pc + {{36{foff[27]}}, foff}; end
    endfunction

    task automatic observe();
        if (timed && !stall_phase)
            check("R9 out_valid timing", 64'(out_valid),
                  64'(q.size() > 0 && q[0].due == cyc));
        if (out_valid) begin
            if (q.size() == 0) check("R10 unexpected result", 64'(1), 64'(0));
            else begin
                check({q[0].tag, " code"}, 64'(out_code), 64'(q[0].code));
                check({q[0].tag, " target"}, out_target, q[0].target);
                if (out_ready) void'(q.pop_front());
            end
        end
    endtask

    task automatic cycle_begin();
        @(negedge clk);
        out_ready = stall_phase ? 1'($urandom % 2) : 1'b1;
        observe();
    endtask

    task automatic send(string tag, logic [1:0] mode, logic [3:0] al, logic [19:0] sz,
                        logic [63:0] vec, longint d, logic [27:0] foff);
        exp_t e;
        cycle_begin();
        in_valid = 1'b1; in_mode = mode; in_align = al; in_size = sz; in_vec = vec;
        in_fail_off = foff;
        in_ptr = in_pc + {{36{in_base_off[27]}}, in_base_off} + 64'(d);
        #1;
        while (!in_ready) begin cycle_begin(); #1; end
        model(mode, al, sz, vec, in_ptr, in_pc, in_base_off, foff, e.code, e.target);
        e.due = stall_phase ? 0 : cyc + 2;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin cycle_begin(); in_valid = 1'b0; end
    endtask

    initial begin
        in_pc = 64'h0000_0000_4000_0000;
        in_base_off = 28'h0010000;
        repeat (3) @(negedge clk);
        check("R11 out_valid in reset", 64'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 out_valid after reset", 64'(out_valid), 0);
        check("R11 out_code after reset", 64'(out_code), 0);
        check("R11 in_ready after reset", 64'(in_ready), 1);

        send("R1 last slot", 2'b00, 3, 10, 0, 72, 0);
        send("R1 first slot", 2'b00, 3, 10, 0, 0, 0);
        send("R2 end of region", 2'b00, 3, 10, 0, 80, 0);
        send("R2 below base", 2'b00, 3, 10, 0, -8, 0);
        send("R3 misaligned", 2'b00, 3, 10, 0, 12, 0);
        send("R3 misaligned high align", 2'b00, 15, 5, 0, 64'h8001, 0);
        send("R4 bit63 set", 2'b10, 0, 64, 64'h8000_0000_0000_0001, 63, 0);
        send("R4 bit62 clear", 2'b10, 0, 64, 64'h8000_0000_0000_0001, 62, 0);
        send("R5 index 35 over narrow", 2'b01, 0, 40, '1, 35, 0);
        send("R5 index 31 passes", 2'b01, 0, 40, '1, 31, 0);
        send("R5 upper vector ignored", 2'b01, 0, 40, 64'hFFFF_FFFF_0000_0000, 3, 0);
        send("R6 zero size", 2'b00, 0, 0, '1, 0, 0);
        send("R6 zero size vector", 2'b10, 0, 0, '1, 0, 0);
        send("R7 single hit", 2'b11, 7, 0, 0, 0, 0);
        send("R7 single miss", 2'b11, 3, 100, '1, 8, 0);
        send("R8 jump forward", 2'b00, 2, 4, 0, 400, 28'h0000100);
        send("R8 jump backward", 2'b11, 0, 0, 0, 1, 28'hFFFFF00);
        send("R8 pass ignores handler", 2'b00, 2, 4, 0, 4, 28'h0000100);
        for (int i = 0; i < 200; i++)
            send("R9 back to back", 2'($urandom), 4'($urandom % 5), 20'($urandom % 70),
                 {$urandom, $urandom}, longint'($urandom % 600) - 100,
                 ($urandom % 2) ? 28'($urandom) : 28'h0);
        idle(4);

        stall_phase = 1;
        timed = 0;
        for (int i = 0; i < 300; i++)
            send("R10 stall", 2'($urandom), 4'($urandom % 5), 20'($urandom % 70),
                 {$urandom, $urandom}, longint'($urandom % 600) - 100,
                 ($urandom % 2) ? 28'($urandom) : 28'h0);
        idle(1);
        stall_phase = 0;
        idle(6);
        check("R10 all results delivered", 64'(q.size()), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule